// File: doc/BRIEF.md
# Host-State and Power-Mode Controller

This block watches the status lines a host system presents to a companion controller: a power-good level, an active-low lid switch and an active-low host-suspended flag, together with a small set of general interrupt lines. It classifies the host into one of four states with a fixed priority and announces each change with a one-clock pulse that coincides with the new state code.

From the same inputs, plus a host-transaction flag and a vector of timer-user requests such as LED blinking or a running PWM channel, it chooses a device power level: stop, wait or run. Stop is the resting level. Wait is chosen only while a timer user needs a running clock. Run is held while an event waits to be serviced, while an interrupt line stays asserted, or while a host transaction is in progress. A clock-enable request follows the chosen level. All pins are plain levels; the block has no streaming interface, so no back-pressure rules apply.

Top module: `host_pm_ctrl`

## Requirements
- R1: After reset the state code is 0 (normal), the mode code is 0 (stop), the change pulse is low and the clock-enable request is low.
- R2: Each status line (power-good, lid, host-suspended, each interrupt line) passes a two-flop synchroniser and takes a new value only after the synchronised sample has differed from the accepted value for DEB_LEN consecutive clocks; a shorter pulse has no effect on any output.
- R3: While accepted power-good is 0 the state code is 3 (critical), whatever the lid and host-suspended lines show.
- R4: With power-good 1 and the lid line low the state code is 2 (lid closed), whatever host-suspended shows.
- R5: With power-good 1 and the lid line high, the state code is 1 (host suspend) when host-suspended is low and 0 (normal) when it is high.
- R6: The state code is registered one clock after the accepted inputs change; state_chg_o is high for exactly the one clock in which the state code takes a different value and low otherwise.
- R7: A rising or falling accepted edge on power-good, lid or any interrupt line marks an event pending; host-suspended edges do not. The pending mark clears on a clock where evt_done_i is high and no new edge arrives (a new edge wins).
- R8: Run (mode code 2) is requested while an event is pending, while any accepted interrupt line is high, or while host_xact_i is high.
- R9: Without a run reason, wait (mode code 1) is requested while any timer_req_i bit is high, else stop (mode code 0); mode_o shows the request of the previous clock and never takes code 3.
- R10: clk_en_o is high exactly while mode_o is not stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Power-good status, asynchronous |
| lid_n_i | input | 1 | Lid closed, active low, asynchronous |
| hsus_n_i | input | 1 | Host suspended, active low, asynchronous |
| gint_i | input | NGINT | General interrupt lines, active high, asynchronous |
| timer_req_i | input | NTMR | Timer users needing a running clock |
| host_xact_i | input | 1 | Host transaction in progress |
| evt_done_i | input | 1 | Pending event has been serviced |
| state_o | output | 2 | Host state: 0 normal, 1 host suspend, 2 lid closed, 3 critical |
| state_chg_o | output | 1 | One-clock pulse with each new state code |
| mode_o | output | 2 | Power mode: 0 stop, 1 wait, 2 run |
| clk_en_o | output | 1 | Clock-enable request |

## Verification
A wrong accepted input value or a miscounted debounce window shows at state_o within one clock of the moment the accepted value should have moved, and a lost or phantom edge shows two clocks later as a missing or unexpected run level on mode_o. A stuck pending mark keeps mode_o at run after evt_done_i, which appears on the following clock. Because every output is compared against an independent model on each clock, any such divergence is reported in the first cycle it reaches a port.

// File: rtl/host_pm_pkg.sv
package host_pm_pkg;
  typedef enum logic [1:0] {
    HS_NORMAL   = 2'd0,
    HS_SUSPEND  = 2'd1,
    HS_LID      = 2'd2,
    HS_CRITICAL = 2'd3
  } host_state_e;

  typedef enum logic [1:0] {
    PM_STOP = 2'd0,
    PM_WAIT = 2'd1,
    PM_RUN  = 2'd2
  } pm_mode_e;

  localparam int unsigned IDX_PWR  = 0;
  localparam int unsigned IDX_LID  = 1;
  localparam int unsigned IDX_HSUS = 2;
  localparam int unsigned IDX_GINT = 3;
endpackage

// File: rtl/hpc_sync_deb.sv
module hpc_sync_deb #(
  parameter int unsigned W       = 5,
  parameter int unsigned DEB_LEN = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] edge_o
);
  localparam int unsigned CW = $clog2(DEB_LEN + 1);

  logic [W-1:0] lvl_q;
  logic [W-1:0] lvl_dly_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic          meta_q;
    logic          smp_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[b];
        smp_q  <= RST_VAL[b];
        run_q  <= '0;
        lvl_q[b] <= RST_VAL[b];
      end else begin
        meta_q <= raw_i[b];
        smp_q  <= meta_q;
        if (smp_q == lvl_q[b]) begin
          run_q <= '0;
        end else if (run_q == CW'(DEB_LEN - 1)) begin
          lvl_q[b] <= smp_q;
          run_q    <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_dly_q <= RST_VAL;
    else         lvl_dly_q <= lvl_q;
  end

  assign lvl_o  = lvl_q;
  assign edge_o = lvl_q ^ lvl_dly_q;
endmodule

// File: rtl/hpc_state_dec.sv
module hpc_state_dec
  import host_pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok,
  input  logic       lid_n,
  input  logic       hsus_n,
  output logic [1:0] state_o,
  output logic       chg_o
);
  host_state_e nxt;
  host_state_e state_q;
  logic        chg_q;

  always_comb begin
    if (!pwr_ok)      nxt = HS_CRITICAL;
    else if (!lid_n)  nxt = HS_LID;
    else if (!hsus_n) nxt = HS_SUSPEND;
    else              nxt = HS_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_NORMAL;
      chg_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      chg_q   <= (nxt != state_q);
    end
  end

  assign state_o = state_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/hpc_mode_sel.sv
module hpc_mode_sel
  import host_pm_pkg::*;
#(
  parameter int unsigned NTMR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_edge,
  input  logic            evt_done,
  input  logic            int_active,
  input  logic            host_xact,
  input  logic [NTMR-1:0] timer_req,
  output logic [1:0]      mode_o,
  output logic            clk_en_o,
  output logic            pend_o
);
  pm_mode_e want;
  pm_mode_e mode_q;
  logic     en_q;
  logic     pend_q;

  always_comb begin
    if (pend_q || int_active || host_xact) want = PM_RUN;
    else if (|timer_req)                   want = PM_WAIT;
    else                                   want = PM_STOP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_STOP;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= want;
      en_q   <= (want != PM_STOP);
      pend_q <= evt_edge | (pend_q & ~evt_done);
    end
  end

  assign mode_o   = mode_q;
  assign clk_en_o = en_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/host_pm_ctrl.sv
module host_pm_ctrl
  import host_pm_pkg::*;
#(
  parameter int unsigned NGINT   = 2,
  parameter int unsigned NTMR    = 2,
  parameter int unsigned DEB_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic             lid_n_i,
  input  logic             hsus_n_i,
  input  logic [NGINT-1:0] gint_i,
  input  logic [NTMR-1:0]  timer_req_i,
  input  logic             host_xact_i,
  input  logic             evt_done_i,
  output logic [1:0]       state_o,
  output logic             state_chg_o,
  output logic [1:0]       mode_o,
  output logic             clk_en_o
);
  localparam int unsigned NSTAT = IDX_GINT + NGINT;
  localparam logic [NSTAT-1:0] STAT_RST = {{NGINT{1'b0}}, 3'b111};

  logic [NSTAT-1:0] raw;
  logic [NSTAT-1:0] lvl;
  logic [NSTAT-1:0] edg;
  logic             evt_edge;
  logic             int_active;
  logic             pend;

  assign raw = {gint_i, hsus_n_i, lid_n_i, pwr_ok_i};

  hpc_sync_deb #(
    .W       (NSTAT),
    .DEB_LEN (DEB_LEN),
    .RST_VAL (STAT_RST)
  ) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .lvl_o  (lvl),
    .edge_o (edg)
  );

  // host-suspended edges change the state but are not events
  assign evt_edge   = edg[IDX_PWR] | edg[IDX_LID] | (|edg[NSTAT-1:IDX_GINT]);
  assign int_active = |lvl[NSTAT-1:IDX_GINT];

  hpc_state_dec u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_ok  (lvl[IDX_PWR]),
    .lid_n   (lvl[IDX_LID]),
    .hsus_n  (lvl[IDX_HSUS]),
    .state_o (state_o),
    .chg_o   (state_chg_o)
  );

  hpc_mode_sel #(
    .NTMR (NTMR)
  ) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_edge   (evt_edge),
    .evt_done   (evt_done_i),
    .int_active (int_active),
    .host_xact  (host_xact_i),
    .timer_req  (timer_req_i),
    .mode_o     (mode_o),
    .clk_en_o   (clk_en_o),
    .pend_o     (pend)
  );
endmodule

// File: rtl/host_pm_ctrl_chk.sv
module host_pm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_lvl,
  input logic       pend,
  input logic       host_xact_i,
  input logic [1:0] state_o,
  input logic       state_chg_o,
  input logic [1:0] mode_o,
  input logic       clk_en_o
);
  a_r6_pulse_has_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_chg_o |-> (state_o != $past(state_o)));

  a_r6_change_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> state_chg_o);

  a_r3_critical: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_lvl |=> (state_o == 2'd3));

  a_r7_pending_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> (mode_o == 2'd2));

  a_r8_xact_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_xact_i |=> (mode_o == 2'd2));

  a_r9_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  a_r10_clk_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o == (mode_o != 2'd0));
endmodule

bind host_pm_ctrl host_pm_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_lvl     (lvl[0]),
  .pend        (pend),
  .host_xact_i (host_xact_i),
  .state_o     (state_o),
  .state_chg_o (state_chg_o),
  .mode_o      (mode_o),
  .clk_en_o    (clk_en_o)
);

// File: tb/host_pm_ctrl_bench.sv
module host_pm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;
  localparam int NIN = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b1, lid_n = 1'b1, hsus_n = 1'b1;
  logic [1:0] gint = 2'b00;
  logic [1:0] treq = 2'b00;
  logic       xact = 1'b0, done = 1'b0;
  logic [1:0] state, mode;
  logic       chg, clk_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_pm_ctrl #(.NGINT(2), .NTMR(2), .DEB_LEN(DEB)) u_host_pm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .lid_n_i(lid_n),
    .hsus_n_i(hsus_n), .gint_i(gint), .timer_req_i(treq),
    .host_xact_i(xact), .evt_done_i(done), .state_o(state),
    .state_chg_o(chg), .mode_o(mode), .clk_en_o(clk_en)
  );

  // behavioural reference: sample history, accepted levels, stability runs
  int hist1[NIN], hist2[NIN], acc[NIN], acc_prev[NIN], runlen[NIN];
  int m_pend, m_mode, m_state, m_chg, m_en;

  function automatic int host_state(int p, int l, int h);
    if (p == 0) return 3;
    if (l == 0) return 2;
    if (h == 0) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIN; i++) begin
        hist1[i] = (i < 3) ? 1 : 0; hist2[i] = hist1[i];
        acc[i] = hist1[i]; acc_prev[i] = hist1[i]; runlen[i] = 0;
      end
      m_pend = 0; m_mode = 0; m_state = 0; m_chg = 0; m_en = 0;
    end else begin
      int raw[NIN];
      int ev, ints, want, ns;
      raw[0] = pwr_ok; raw[1] = lid_n; raw[2] = hsus_n; raw[3] = gint[0]; raw[4] = gint[1];
      ev = (acc[0] != acc_prev[0]) || (acc[1] != acc_prev[1]) ||
           (acc[3] != acc_prev[3]) || (acc[4] != acc_prev[4]);
      ints = acc[3] || acc[4];
      want = (m_pend || ints || xact) ? 2 : ((treq != 0) ? 1 : 0);
      ns = host_state(acc[0], acc[1], acc[2]);
      m_chg = (ns != m_state);
      m_state = ns;
      m_mode = want;
      m_en = (want != 0);
      m_pend = ev || (m_pend && !done);
      for (int i = 0; i < NIN; i++) begin
        acc_prev[i] = acc[i];
        if (hist2[i] == acc[i]) runlen[i] = 0;
        else if (runlen[i] == DEB - 1) begin acc[i] = hist2[i]; runlen[i] = 0; end
        else runlen[i] = runlen[i] + 1;
        hist2[i] = hist1[i];
        hist1[i] = raw[i];
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(state,  m_state, "R2/R3/R4/R5 state_o");
      chk(chg,    m_chg,   "R6 state_chg_o");
      chk(mode,   m_mode,  "R7/R8/R9 mode_o");
      chk(clk_en, m_en,    "R10 clk_en_o");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    chk(state, 0, "R1 reset state");
    chk(mode, 0, "R1 reset mode");
    chk(chg, 0, "R1 reset pulse");
    chk(clk_en, 0, "R1 reset clk_en");
    cmp_on = 1'b1;

    hsus_n = 1'b0; step(12);
    chk(state, 1, "R5 host suspend");
    chk(mode, 0, "R7 suspend edge is no event");
    hsus_n = 1'b1; step(12);
    chk(state, 0, "R5 normal");

    lid_n = 1'b0; hsus_n = 1'b0; step(12);
    chk(state, 2, "R4 lid closed");
    chk(mode, 2, "R7 lid edge pending run");
    done = 1'b1; step(1); done = 1'b0; step(3);
    chk(mode, 0, "R7 pending cleared, stop");

    pwr_ok = 1'b0; step(12);
    chk(state, 3, "R3 critical over lid");
    lid_n = 1'b1; step(12);
    chk(state, 3, "R3 critical over suspend");
    done = 1'b1; step(1); done = 1'b0;
    pwr_ok = 1'b1; hsus_n = 1'b1; step(12);
    chk(state, 0, "R5 back to normal");
    done = 1'b1; step(1); done = 1'b0; step(3);

    pwr_ok = 1'b0; step(2); pwr_ok = 1'b1; step(12);
    chk(state, 0, "R2 short glitch ignored");
    chk(mode, 0, "R2 short glitch no event");
    pwr_ok = 1'b0; step(DEB - 1); pwr_ok = 1'b1; step(12);
    chk(state, 0, "R2 glitch one below window ignored");

    treq = 2'b10; step(3);
    chk(mode, 1, "R9 timer wait");
    chk(clk_en, 1, "R10 clk_en in wait");
    xact = 1'b1; step(2);
    chk(mode, 2, "R8 host transaction run");
    xact = 1'b0; step(2);
    chk(mode, 1, "R9 back to wait");
    gint = 2'b01; step(12);
    done = 1'b1; step(2); done = 1'b0;
    chk(mode, 2, "R8 interrupt level holds run");
    gint = 2'b00; step(12);
    done = 1'b1; step(2); done = 1'b0; step(2);
    chk(mode, 1, "R9 wait after interrupt");
    treq = 2'b00; step(2);
    chk(mode, 0, "R9 stop default");
    chk(clk_en, 0, "R10 clk_en low in stop");

    done = 1'b1; lid_n = 1'b0; step(12);
    lid_n = 1'b1; step(12);
    done = 1'b0; step(2);
    chk(mode, 0, "R7 edge with done held, cleared");

    step(4);
    cmp_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule